// File: doc/BRIEF.md
# Low Memory Remap Translator

The translator maps a page number as seen by a memory controller to a physical page number when the firmware has opened a hole below 4 GiB for device space. The pages covered by that hole are moved to a remap window higher in the address map. Three 16-bit configuration values set the layout: the top of low memory, the window base and the window limit. Each value is written through a simple select/data write port and is scaled into page units inside the block.

A lookup is presented with `in_valid` and `in_page`. The result appears one cycle later on `out_valid`, `out_page` and `out_err`. A page that falls below the top of low memory passes through unchanged. A page at or above page 0x100000 but below the window base also passes through unchanged. Every other page is moved into the window. When the moved page is not below the window limit, the block returns a fixed fallback page, the last page of low memory, and flags an error.

Top module: `lmr_xlate_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid`, `out_err` and `out_page` are zero. Reset clears all three configuration values to zero, so the first lookup after reset returns `out_err`=1 with `out_page`=0xFFFFFFFF.
- R2: A write with `cfg_we`=1 loads `cfg_wdata` into one value chosen by `cfg_sel`: 0 for the top of low memory, 1 for the window base, 2 for the window limit. `cfg_sel`=3 changes nothing. A lookup issued in the same cycle as a write uses the values held before that write.
- R3: A page below the top of low memory (`cfg_wdata` of selector 0 shifted left by 4) is returned unchanged, with `out_err`=0.
- R4: A page that is at least 0x100000 and below the window base (selector 1 value shifted left by 14) is returned unchanged, with `out_err`=0.
- R5: Any other page is returned as (page − top of low memory + window base), with `out_err`=0, when that result is below the window limit (selector 2 value shifted left by 14).
- R6: When the moved page is not below the window limit, `out_page` is the top of low memory minus one and `out_err`=1.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `out_err` is never high while `out_valid` is low.
- R8: After a cycle with `in_valid` low, `out_page` keeps its previous value and `out_err` is 0.
- R9: The subtraction and addition are unsigned and taken modulo 2^32. Only the limit test classifies the wrapped result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Value select: 0 top of low memory, 1 window base, 2 window limit, 3 none |
| cfg_wdata | input | 16 | Configuration write data |
| in_valid | input | 1 | Lookup request |
| in_page | input | 32 | Controller page number |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_page | output | 32 | Physical page number |
| out_err | output | 1 | Result lay outside the remap window |

## Verification
Several properties are checked on every cycle: the one-cycle valid pipeline, the rule that an error only appears with a valid result, the fallback page that accompanies every error, pass-through below the top of low memory, and the hold behaviour between lookups. Other behaviours can only be shown by the bench scenarios, because they depend on chosen configurations and on where the window boundaries fall. These are the window arithmetic, the upper pass-through band, the exact limit boundary, modulo-2^32 wraparound, the ignored selector, write-versus-lookup ordering and the reset-cleared layout.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  localparam int unsigned PAGE_W     = 32;
  localparam int unsigned CFG_W      = 16;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned TOLM_SHIFT = 4;
  localparam int unsigned WIN_SHIFT  = 14;
  localparam logic [PAGE_W-1:0] HIGH_START = 32'h0010_0000;

  typedef enum logic [SEL_W-1:0] {
    SEL_TOLM  = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_LIMIT = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic              err;
  } xlate_res_t;
endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs
  import lmr_pkg::*;
#(
  parameter int unsigned CW = CFG_W,
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned LO_SHIFT = TOLM_SHIFT,
  parameter int unsigned HI_SHIFT = WIN_SHIFT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [CW-1:0] wdata,
  output logic [PW-1:0] tolm_pages,
  output logic [PW-1:0] base_pages,
  output logic [PW-1:0] limit_pages
);
  localparam int unsigned NREG = 3;
  localparam int unsigned PAD_LO = PW - CW - LO_SHIFT;
  localparam int unsigned PAD_HI = PW - CW - HI_SHIFT;

  logic [CW-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[i] <= '0;
      end else if (we && (sel == SEL_W'(i))) begin
        regs_q[i] <= wdata;
      end
    end
  end

  assign tolm_pages  = {{PAD_LO{1'b0}}, regs_q[SEL_TOLM],  {LO_SHIFT{1'b0}}};
  assign base_pages  = {{PAD_HI{1'b0}}, regs_q[SEL_BASE],  {HI_SHIFT{1'b0}}};
  assign limit_pages = {{PAD_HI{1'b0}}, regs_q[SEL_LIMIT], {HI_SHIFT{1'b0}}};
endmodule

// File: rtl/lmr_window_calc.sv
module lmr_window_calc
  import lmr_pkg::*;
#(
  parameter int unsigned PW = PAGE_W,
  parameter logic [PW-1:0] HIGH_FLOOR = HIGH_START
) (
  input  logic [PW-1:0] page,
  input  logic [PW-1:0] tolm_pages,
  input  logic [PW-1:0] base_pages,
  input  logic [PW-1:0] limit_pages,
  output logic [PW-1:0] res_page,
  output logic          res_err
);
  logic          below_tolm;
  logic          in_high_band;
  logic [PW-1:0] moved;
  logic          moved_ok;

  always_comb begin
    below_tolm   = page < tolm_pages;
    in_high_band = (page >= HIGH_FLOOR) && (page < base_pages);
    moved        = (page - tolm_pages) + base_pages;
    moved_ok     = moved < limit_pages;
    if (below_tolm || in_high_band) begin
      res_page = page;
      res_err  = 1'b0;
    end else if (moved_ok) begin
      res_page = moved;
      res_err  = 1'b0;
    end else begin
      res_page = tolm_pages - PW'(1);
      res_err  = 1'b1;
    end
  end
endmodule

// File: rtl/lmr_out_stage.sv
module lmr_out_stage
  import lmr_pkg::*;
#(
  parameter int unsigned PW = PAGE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_in,
  input  logic [PW-1:0] page_in,
  input  logic          err_in,
  output logic          vld_out,
  output logic [PW-1:0] page_out,
  output logic          err_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_out  <= 1'b0;
      page_out <= '0;
      err_out  <= 1'b0;
    end else begin
      vld_out <= vld_in;
      err_out <= vld_in & err_in;
      if (vld_in) begin
        page_out <= page_in;
      end
    end
  end
endmodule

// File: rtl/lmr_xlate_top.sv
module lmr_xlate_top
  import lmr_pkg::*;
#(
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned CW = CFG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          in_valid,
  input  logic [PW-1:0] in_page,
  output logic          out_valid,
  output logic [PW-1:0] out_page,
  output logic          out_err
);
  logic [PW-1:0] tolm_pages;
  logic [PW-1:0] base_pages;
  logic [PW-1:0] limit_pages;
  logic [PW-1:0] calc_page;
  logic          calc_err;

  lmr_cfg_regs #(.CW(CW), .PW(PW)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .sel        (cfg_sel),
    .wdata      (cfg_wdata),
    .tolm_pages (tolm_pages),
    .base_pages (base_pages),
    .limit_pages(limit_pages)
  );

  lmr_window_calc #(.PW(PW)) u_calc (
    .page       (in_page),
    .tolm_pages (tolm_pages),
    .base_pages (base_pages),
    .limit_pages(limit_pages),
    .res_page   (calc_page),
    .res_err    (calc_err)
  );

  lmr_out_stage #(.PW(PW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .vld_in  (in_valid),
    .page_in (calc_page),
    .err_in  (calc_err),
    .vld_out (out_valid),
    .page_out(out_page),
    .err_out (out_err)
  );
endmodule

// File: rtl/lmr_xlate_chk.sv
module lmr_xlate_chk #(
  parameter int unsigned PW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [PW-1:0] in_page,
  input logic          out_valid,
  input logic [PW-1:0] out_page,
  input logic          out_err,
  input logic [PW-1:0] tolm_pages
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_err_with_valid_R7: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_valid);
  assert_fallback_page_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!out_err || (out_page == $past(tolm_pages) - PW'(1))));
  assert_low_passthrough_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_page < tolm_pages)) |=> (!out_err && out_page == $past(in_page)));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_page) && !out_err));
endmodule

bind lmr_xlate_top lmr_xlate_chk #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_page   (in_page),
  .out_valid (out_valid),
  .out_page  (out_page),
  .out_err   (out_err),
  .tolm_pages(tolm_pages)
);

// File: tb/tb_lmr_xlate_top.sv
module tb_lmr_xlate_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_page = '0;
  logic        out_valid;
  logic [31:0] out_page;
  logic        out_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lmr_xlate_top dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_page(in_page),
    .out_valid(out_valid), .out_page(out_page), .out_err(out_err)
  );

  // layout: low top 0x80000, window 0x200000..0x280000
  localparam int NV = 9;
  localparam logic [31:0] V_IN [NV] = '{
    32'h0000_0123, 32'h0007_FFFF, 32'h0008_0000, 32'h0009_0000, 32'h000F_FFFF,
    32'h0010_0000, 32'h001F_FFFF, 32'h0020_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] V_OUT [NV] = '{
    32'h0000_0123, 32'h0007_FFFF, 32'h0020_0000, 32'h0021_0000, 32'h0027_FFFF,
    32'h0010_0000, 32'h001F_FFFF, 32'h0007_FFFF, 32'h0017_FFFF};
  localparam logic V_ERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam string V_REQ [NV] = '{"R3", "R3", "R5", "R5", "R5", "R4", "R4", "R6", "R9"};

  task automatic check(string req, logic [31:0] act_p, logic act_e, logic act_v,
                       logic [31:0] exp_p, logic exp_e, logic exp_v);
    checks++;
    if (act_p !== exp_p || act_e !== exp_e || act_v !== exp_v) begin
      failures++;
      $display("FAIL %s: page=%h err=%b vld=%b expected page=%h err=%b vld=%b",
               req, act_p, act_e, act_v, exp_p, exp_e, exp_v);
    end
  endtask

  task automatic cfg_write(logic [1:0] s, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(string req, logic [31:0] p, logic [31:0] exp_p, logic exp_e);
    @(negedge clk);
    in_valid = 1'b1; in_page = p;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_page, out_err, out_valid, exp_p, exp_e, 1'b1);
  endtask

  initial begin
    // R1: reset outputs
    repeat (3) @(negedge clk);
    check("R1", out_page, out_err, out_valid, 32'h0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", out_page, out_err, out_valid, 32'h0, 1'b0, 1'b0);
    // R1: cleared layout -> everything out of range, fallback 0 - 1
    lookup("R1", 32'h0000_0005, 32'hFFFF_FFFF, 1'b1);

    cfg_write(2'd0, 16'h8000);
    cfg_write(2'd1, 16'h0080);
    cfg_write(2'd2, 16'h00A0);

    for (int i = 0; i < NV; i++) lookup(V_REQ[i], V_IN[i], V_OUT[i], V_ERR[i]);

    // R8: hold after idle cycle
    @(negedge clk);
    check("R8", out_page, out_err, out_valid, 32'h0017_FFFF, 1'b0, 1'b0);

    // R2: selector 3 ignored
    cfg_write(2'd3, 16'hFFFF);
    lookup("R2", 32'h0008_0000, 32'h0020_0000, 1'b0);
    lookup("R2", 32'h0020_0000, 32'h0007_FFFF, 1'b1);

    // R6: exact limit boundary with limit 0x240000
    cfg_write(2'd2, 16'h0090);
    lookup("R5", 32'h000B_FFFF, 32'h0023_FFFF, 1'b0);
    lookup("R6", 32'h000C_0000, 32'h0007_FFFF, 1'b1);

    // R2: write and lookup in the same cycle use old layout
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h0001;
    in_valid = 1'b1; in_page = 32'h0000_0123;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check("R2", out_page, out_err, out_valid, 32'h0000_0123, 1'b0, 1'b1);
    lookup("R2", 32'h0000_0123, 32'h0020_0113, 1'b0);

    // R7: valid drops, err low
    @(negedge clk);
    check("R7", out_page, out_err, out_valid, 32'h0020_0113, 1'b0, 1'b0);

    // R7: back-to-back lookups
    @(negedge clk);
    in_valid = 1'b1; in_page = 32'h0000_000F;
    @(negedge clk);
    check("R7", out_page, out_err, out_valid, 32'h0000_000F, 1'b0, 1'b1);
    in_page = 32'h0030_0000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6", out_page, out_err, out_valid, 32'h0000_000F, 1'b1, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule